// File: doc/BRIEF.md
# Counter-Based Register File with In-Place Post-Update

This block is a small general-purpose register file whose storage elements are loadable up/down counters rather than plain latches. Results from the execution path arrive on a single write bus and are loaded into one selected register. Separately, one register per cycle may be stepped by one, up or down, inside the register file itself. Address post-increment and post-decrement therefore need no second pass through the execution path, and an instruction that post-updates a register keeps the same two-cycle timing as one that does not.

Two read ports select any register, including the same one, and present its value combinationally. Three condition flags are derived from whatever value the second read port presents: its least significant bit, its most significant bit and an all-zero indication. Because the flags are recomputed from the read value instead of being captured from the write bus, they are valid for any operand placed on that port.

Top module: `cnt_regfile`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising clock edge) clears every register to 0x0000.
- R2: With `wr_en` high at a rising edge, register `wr_addr` takes the value of `wr_data`, visible on the read ports after that edge.
- R3: When `wr_en` and `cnt_en` are high in the same cycle and `wr_addr` equals `cnt_addr`, the register takes `wr_data` and the count step is dropped.
- R4: With `cnt_en` high and `cnt_up` = 1, register `cnt_addr` increases by one at the edge, wrapping from 0xFFFF to 0x0000.
- R5: With `cnt_en` high and `cnt_up` = 0, register `cnt_addr` decreases by one at the edge, wrapping from 0x0000 to 0xFFFF.
- R6: A write to one register and a count of a different register in the same cycle both take effect at that edge.
- R7: `rd_a_data` and `rd_b_data` show registers `rd_a_addr` and `rd_b_addr` combinationally and independently; both ports may select the same register.
- R8: A read of a register in the cycle it is written or counted returns its value from before that edge.
- R9: `flag_lsb` equals bit 0 and `flag_msb` equals bit 15 of `rd_b_data`, and `flag_zero` is high exactly when `rd_b_data` is 0x0000, for any register selected on port B.
- R10: A register that is neither written nor counted keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Load the write bus into the addressed register |
| wr_addr | input | 2 | Register selected for loading |
| wr_data | input | 16 | Result bus value to load |
| cnt_en | input | 1 | Step the addressed register by one |
| cnt_up | input | 1 | Step direction: 1 = +1, 0 = -1 |
| cnt_addr | input | 2 | Register selected for stepping |
| rd_a_addr | input | 2 | Register selected on read port A |
| rd_b_addr | input | 2 | Register selected on read port B |
| rd_a_data | output | 16 | Read port A value |
| rd_b_data | output | 16 | Read port B value |
| flag_lsb | output | 1 | Bit 0 of the port B value |
| flag_msb | output | 1 | Bit 15 of the port B value |
| flag_zero | output | 1 | Port B value is all zeros |

## Verification
Every register is visible through both read ports without latency, so a corrupted counter, a lost load or a wrongly applied step shows up on the first read of that register after the faulty edge, one cycle at the earliest. Wrap-around at both ends, the load-over-count priority and the same-cycle read of a changing register are each driven deliberately and read back the following cycle. The flags are compared against the port B value on every check, so a fault in their derivation appears in the same cycle as the read.

// File: rtl/cnt_regfile_pkg.sv
// Package: shared defaults and the condition flag bundle of the counter
// register file. Assumes nothing beyond IEEE 1800-2017.
package cnt_regfile_pkg;
    localparam int RF_DATA_W   = 16;
    localparam int RF_NUM_REGS = 4;

    // Condition flags derived from a read value.
    typedef struct packed {
        logic lsb;
        logic msb;
        logic zero;
    } cond_flags_t;
endpackage

// File: rtl/cnt_reg_cell.sv
// Module: one register implemented as a loadable up/down counter.
// Load has priority over counting; arithmetic wraps modulo 2**DATA_W.
// Assumes the caller asserts at most one load and one count per cycle.
module cnt_reg_cell #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_val,
    input  logic              cnt,
    input  logic              up,
    output logic [DATA_W-1:0] q
);
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    // Purpose: reset, load, or step the stored value by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (ld) begin
            q <= ld_val;
        end else if (cnt) begin
            q <= up ? q + ONE : q - ONE;
        end
    end

    // R1: reset leaves the cell at zero
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> q == '0);
    // R2, R3: a load always wins over a coincident count
    a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> q == $past(ld_val));
    // R4: count up adds one with wrap
    a_r4_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && cnt && up) |=> q == $past(q) + ONE);
    // R5: count down subtracts one with wrap
    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && cnt && !up) |=> q == $past(q) - ONE);
    // R10: no request keeps the value
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !cnt) |=> $stable(q));
endmodule

// File: rtl/rd_port_mux.sv
// Module: combinational selection of one register onto a read port.
// Assumes sel is always within 0..NUM_REGS-1.
module rd_port_mux #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 4,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic [SEL_W-1:0]                sel,
    output logic [DATA_W-1:0]               dout
);
    // Purpose: route the selected register to the port.
    always_comb begin
        dout = regs[sel];
    end
endmodule

// File: rtl/cond_flag_gen.sv
// Module: derives LSB, MSB and zero flags from a read value.
// Assumes val is the settled port value; purely combinational.
module cond_flag_gen
    import cnt_regfile_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] val,
    output cond_flags_t       flags
);
    // Purpose: recompute all three flags from the value itself.
    always_comb begin
        flags.lsb  = val[0];
        flags.msb  = val[DATA_W-1];
        flags.zero = ~|val;
    end
endmodule

// File: rtl/cnt_regfile.sv
// Module: register file of loadable up/down counters with one write bus,
// one in-place count request, two read ports and flags from port B.
// Assumes addresses are in range; reads show pre-edge contents.
module cnt_regfile
    import cnt_regfile_pkg::*;
#(
    parameter int DATA_W   = RF_DATA_W,
    parameter int NUM_REGS = RF_NUM_REGS,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cnt_en,
    input  logic              cnt_up,
    input  logic [ADDR_W-1:0] cnt_addr,
    input  logic [ADDR_W-1:0] rd_a_addr,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data,
    output logic              flag_lsb,
    output logic              flag_msb,
    output logic              flag_zero
);
    logic [NUM_REGS-1:0][DATA_W-1:0] reg_q;
    logic [NUM_REGS-1:0]             ld_sel;
    logic [NUM_REGS-1:0]             cnt_sel;
    cond_flags_t                     b_flags;

    // Purpose: decode write and count requests into per-register strobes.
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            ld_sel[i]  = wr_en  && (wr_addr  == ADDR_W'(i));
            cnt_sel[i] = cnt_en && (cnt_addr == ADDR_W'(i));
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
        cnt_reg_cell #(.DATA_W(DATA_W)) i_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (ld_sel[g]),
            .ld_val (wr_data),
            .cnt    (cnt_sel[g]),
            .up     (cnt_up),
            .q      (reg_q[g])
        );
    end

    rd_port_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) i_rd_a (
        .regs (reg_q),
        .sel  (rd_a_addr),
        .dout (rd_a_data)
    );

    rd_port_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) i_rd_b (
        .regs (reg_q),
        .sel  (rd_b_addr),
        .dout (rd_b_data)
    );

    cond_flag_gen #(.DATA_W(DATA_W)) i_flags (
        .val   (rd_b_data),
        .flags (b_flags)
    );

    // Purpose: expose the flag bundle as plain output bits.
    always_comb begin
        flag_lsb  = b_flags.lsb;
        flag_msb  = b_flags.msb;
        flag_zero = b_flags.zero;
    end

    // R9: a zero value cannot have its end bits set
    a_r9_zero_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        flag_zero |-> (!flag_lsb && !flag_msb));
    // R7: same address on both ports gives the same value
    a_r7_same_sel_same_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == rd_b_addr) |-> (rd_a_data == rd_b_data));
    // R6: a count on another register leaves the written one unaffected
    a_r6_split_ops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cnt_en && wr_addr != cnt_addr && rd_b_addr == wr_addr)
        |=> (rd_b_addr != $past(wr_addr)) || (rd_b_data == $past(wr_data)));
endmodule

// File: tb/test_cnt_regfile.sv
// Bench: scoreboard. The driver task pushes expected read values into a
// queue; the monitor pops and compares them at each falling edge.
module test_cnt_regfile;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, cnt_en, cnt_up;
    logic [1:0]  wr_addr, cnt_addr, rd_a_addr, rd_b_addr;
    logic [15:0] wr_data;
    logic [15:0] rd_a_data, rd_b_data;
    logic        flag_lsb, flag_msb, flag_zero;

    typedef struct {
        logic [15:0] a;
        logic [15:0] b;
        logic        l;
        logic        m;
        logic        z;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [15:0] model [4];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    // pending operations, applied to the model at the next rising edge
    logic        p_rst, p_we, p_ce, p_up;
    logic [1:0]  p_wa, p_ca;
    logic [15:0] p_wd;

    always #2 clk = ~clk;

    cnt_regfile i_cnt_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt_en(cnt_en), .cnt_up(cnt_up),
        .cnt_addr(cnt_addr), .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .flag_lsb(flag_lsb),
        .flag_msb(flag_msb), .flag_zero(flag_zero)
    );

    task automatic step(input logic rs, input logic we, input logic [1:0] wa,
                        input logic [15:0] wd, input logic ce, input logic up,
                        input logic [1:0] ca, input logic [1:0] ra,
                        input logic [1:0] rb, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        if (p_rst) begin
            for (int i = 0; i < 4; i++) model[i] = 16'h0000;
        end else begin
            if (p_we) model[p_wa] = p_wd;
            if (p_ce && !(p_we && p_wa == p_ca))
                model[p_ca] = p_up ? model[p_ca] + 16'd1 : model[p_ca] - 16'd1;
        end
        rst_n = rs; wr_en = we; wr_addr = wa; wr_data = wd;
        cnt_en = ce; cnt_up = up; cnt_addr = ca;
        rd_a_addr = ra; rd_b_addr = rb;
        e.a = model[ra]; e.b = model[rb];
        e.l = model[rb][0]; e.m = model[rb][15]; e.z = (model[rb] == 16'h0000);
        e.tag = tag;
        sb.push_back(e);
        p_rst = !rs; p_we = we; p_wa = wa; p_wd = wd;
        p_ce = ce; p_up = up; p_ca = ca;
    endtask

    // Monitor: compare design outputs with the oldest expectation.
    always @(negedge clk) begin
        exp_t e;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            n_chk++;
            if (rd_a_data !== e.a || rd_b_data !== e.b || flag_lsb !== e.l ||
                flag_msb !== e.m || flag_zero !== e.z) begin
                n_fail++;
                $display("FAIL %s: a=%h b=%h lmz=%b%b%b expected a=%h b=%h lmz=%b%b%b",
                         e.tag, rd_a_data, rd_b_data, flag_lsb, flag_msb, flag_zero,
                         e.a, e.b, e.l, e.m, e.z);
            end
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 0; cnt_en = 0; cnt_up = 0;
        wr_addr = 0; cnt_addr = 0; rd_a_addr = 0; rd_b_addr = 0; wr_data = 0;
        p_rst = 1; p_we = 0; p_ce = 0; p_up = 0; p_wa = 0; p_ca = 0; p_wd = 0;
        for (int i = 0; i < 4; i++) model[i] = 16'h0000;
        @(posedge clk);
        // reset, then reads right after it (R1)
        step(0, 0, 0, 16'h0,    0, 0, 0, 0, 1, "R1 reset");
        step(1, 0, 0, 16'h0,    0, 0, 0, 2, 3, "R1 zero after reset");
        // writes, reading the target in the same cycle (R2, R8)
        step(1, 1, 0, 16'h1234, 0, 0, 0, 0, 0, "R8 read old during write");
        step(1, 1, 1, 16'h8000, 0, 0, 0, 0, 1, "R2 write r0 visible");
        step(1, 1, 2, 16'hFFFF, 0, 0, 0, 1, 1, "R2 R7 same reg both ports");
        step(1, 1, 3, 16'h0000, 0, 0, 0, 2, 2, "R2 R9 all ones flags");
        // flag combinations on port B (R9)
        step(1, 0, 0, 16'h0,    0, 0, 0, 3, 0, "R9 even value flags");
        step(1, 0, 0, 16'h0,    0, 0, 0, 0, 3, "R9 zero flag");
        // wrap up: r2 FFFF -> 0000 (R4), read during count (R8)
        step(1, 0, 0, 16'h0,    1, 1, 2, 2, 2, "R8 read old during count");
        step(1, 0, 0, 16'h0,    1, 0, 3, 2, 2, "R4 wrap up to zero");
        // wrap down: r3 0000 -> FFFF (R5)
        step(1, 0, 0, 16'h0,    0, 0, 0, 0, 3, "R5 wrap down to all ones");
        // load and count on same register (R3)
        step(1, 1, 1, 16'h00AA, 1, 1, 1, 1, 1, "R3 pre");
        step(1, 0, 0, 16'h0,    0, 0, 0, 3, 1, "R3 load beats count");
        // write and count on different registers (R6)
        step(1, 1, 0, 16'h5555, 1, 1, 3, 0, 3, "R6 pre");
        step(1, 0, 0, 16'h0,    0, 0, 0, 0, 3, "R6 both applied");
        // repeated up and down counts
        step(1, 0, 0, 16'h0,    1, 0, 0, 0, 0, "R5 count down r0");
        step(1, 0, 0, 16'h0,    1, 1, 1, 0, 1, "R4 count up r1");
        // idle holds (R10)
        step(1, 0, 0, 16'h0,    0, 0, 0, 0, 1, "R10 hold");
        step(1, 0, 0, 16'h0,    0, 0, 0, 2, 3, "R10 hold others");
        // reset with pending write: reset must win (R1)
        step(0, 1, 2, 16'hBEEF, 0, 0, 0, 2, 0, "R1 reset asserted");
        step(1, 0, 0, 16'h0,    0, 0, 0, 2, 1, "R1 cleared again");
        step(1, 0, 0, 16'h0,    0, 0, 0, 0, 3, "R1 cleared rest");
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #40000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule